// File: doc/BRIEF.md
# Serial Multiply-Accumulate FIR Filter Channel

This block is a single channel of a direct-form FIR filter that computes every tap on one shared multiplier and one shared adder. It runs on a fast clock. A slower sample strobe marks each new input sample, and the sample period spans many more fast cycles than there are taps. When the strobe fires, the channel pushes the new signed 8-bit sample into a 30-deep history. It then spends one fast cycle per tap. It starts with the newest sample times the first coefficient and works towards older samples and higher coefficient indices, summing into a wide signed accumulator.

When the last tap has been added, the channel registers the full-width sum on its result output and raises a one-cycle valid pulse. It then pulls its clock-enable output low. The surrounding logic can use that signal to gate the channel's clock for the rest of the sample period. A mode input selects a 15-tap short filter or a 30-tap long filter at each strobe. Coefficients are loaded one at a time through a write port.

Top module: `fir_serial_channel`

## Requirements
- R1: After a synchronous reset, result_valid, clk_en and overrun are 0 and result is 0.
- R2: When coef_we is 1 at a clock edge, coef_wdata is stored as a signed two's-complement coefficient at index coef_addr (0 to 29). Index k holds the coefficient that multiplies the sample k positions older than the newest.
- R3: When sample_stb and enable are both 1 at a clock edge, sample_in is taken as the newest signed 8-bit sample. Every earlier sample moves one position older, and the history holds 30 samples.
- R4: The result is the sum over k = 0 to N-1 of coefficient k times the sample k positions old. It is a signed 21-bit two's-complement value and is exact for all input and coefficient values.
- R5: N is 30 when half_mode is 0 and 15 when half_mode is 1. In the 15-tap case only coefficients 0 to 14 and the 15 newest samples are used. half_mode is sampled at the accepting strobe edge.
- R6: clk_en is 1 from the accepting strobe edge until the edge N cycles later. At that same later edge, result_valid rises for exactly one cycle and clk_en falls, and clk_en stays low until the next accepted strobe.
- R7: An accepted strobe that arrives while taps are still being summed restarts the computation on the new sample (both samples remain in the history) and sets overrun. overrun stays 1 until reset.
- R8: While enable is 0, strobes are ignored: the history does not move, and clk_en and result_valid stay 0. Dropping enable during a computation abandons it with no valid pulse.
- R9: result changes only at the edge that raises result_valid and otherwise holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast processing clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Channel enable |
| half_mode | input | 1 | 1 selects 15 taps, 0 selects 30 taps |
| sample_stb | input | 1 | One-cycle strobe marking a new sample |
| sample_in | input | 8 | Signed input sample |
| coef_we | input | 1 | Coefficient write enable |
| coef_addr | input | 5 | Coefficient index |
| coef_wdata | input | 8 | Signed coefficient value |
| result | output | 21 | Signed filter output |
| result_valid | output | 1 | One-cycle pulse when result is updated |
| clk_en | output | 1 | High while taps are being computed |
| overrun | output | 1 | Sticky flag for a strobe that arrived mid-computation |

## Verification
An impulse walked through all 30 history positions reads back each coefficient by itself, which separates a wrong tap order or index pairing from a correct sum. A sweep of every sample value in both tap modes, with varied coefficients, exercises sign extension and the half-mode cut-off. All-extreme inputs test the accumulator at its largest positive and negative sums. Back-to-back strobes, strobes with the channel disabled, and a disable in mid-computation tell the restart, ignore and abandon behaviours apart through the next result.

// File: rtl/fir_chan_pkg.sv
package fir_chan_pkg;
  typedef enum logic [1:0] {
    CH_IDLE = 2'd0,
    CH_RUN  = 2'd1,
    CH_DONE = 2'd2
  } ch_state_e;
endpackage

// File: rtl/fir_coef_store.sv
module fir_coef_store #(
  parameter int COEF_W = 8,
  parameter int DEPTH  = 30,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [COEF_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [COEF_W-1:0] rdata
);
  logic [COEF_W-1:0] mem [DEPTH];

  // single write port, asynchronous read (distributed RAM style)
  always_ff @(posedge clk) begin
    if (we && (int'(waddr) < DEPTH)) mem[waddr] <= wdata;
  end

  always_comb begin
    if (int'(raddr) < DEPTH) rdata = mem[raddr];
    else                     rdata = '0;
  end
endmodule

// File: rtl/fir_delay_line.sv
module fir_delay_line #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 30,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_en,
  input  logic [DATA_W-1:0] din,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] dout
);
  logic [DATA_W-1:0] taps [DEPTH];

  always_ff @(posedge clk) begin
    if (rst)           taps[0] <= '0;
    else if (shift_en) taps[0] <= din;
  end

  for (genvar i = 1; i < DEPTH; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst)           taps[i] <= '0;
      else if (shift_en) taps[i] <= taps[i-1];
    end
  end

  always_comb begin
    if (int'(raddr) < DEPTH) dout = taps[raddr];
    else                     dout = '0;
  end
endmodule

// File: rtl/fir_mac.sv
module fir_mac #(
  parameter int DATA_W = 8,
  parameter int COEF_W = 8,
  parameter int ACC_W  = 21,
  localparam int PROD_W = DATA_W + COEF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              step,
  input  logic [DATA_W-1:0] sample,
  input  logic [COEF_W-1:0] coef,
  output logic [ACC_W-1:0]  sum
);
  logic signed [PROD_W-1:0] prod;
  logic signed [ACC_W-1:0]  prod_ext;
  logic signed [ACC_W-1:0]  acc_q;

  // the one multiplier and the one adder of the channel
  assign prod     = $signed(sample) * $signed(coef);
  assign prod_ext = ACC_W'(prod);
  assign sum      = acc_q + prod_ext;

  always_ff @(posedge clk) begin
    if (rst || clear) acc_q <= '0;
    else if (step)    acc_q <= sum;
  end
endmodule

// File: rtl/fir_chan_ctrl.sv
module fir_chan_ctrl
  import fir_chan_pkg::*;
#(
  parameter int TAPS_FULL = 30,
  parameter int TAPS_HALF = 15,
  parameter int ADDR_W    = $clog2(TAPS_FULL)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              sample_stb,
  input  logic              half_mode,
  output logic              shift_en,
  output logic              mac_clear,
  output logic              mac_step,
  output logic              finish,
  output logic [ADDR_W-1:0] tap_idx,
  output logic              clk_en,
  output logic              overrun
);
  localparam logic [ADDR_W-1:0] LAST_FULL = ADDR_W'(TAPS_FULL - 1);
  localparam logic [ADDR_W-1:0] LAST_HALF = ADDR_W'(TAPS_HALF - 1);

  ch_state_e state_q;
  logic      half_q;
  logic      accept;
  logic      last_tap;

  assign accept    = enable && sample_stb;
  assign last_tap  = (tap_idx == (half_q ? LAST_HALF : LAST_FULL));
  assign shift_en  = accept;
  assign mac_clear = accept;
  assign mac_step  = enable && !sample_stb && (state_q == CH_RUN);
  assign finish    = mac_step && last_tap;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= CH_IDLE;
      tap_idx <= '0;
      half_q  <= 1'b0;
      clk_en  <= 1'b0;
      overrun <= 1'b0;
    end else if (!enable) begin
      state_q <= CH_IDLE;
      tap_idx <= '0;
      clk_en  <= 1'b0;
    end else if (sample_stb) begin
      if (state_q == CH_RUN) overrun <= 1'b1;
      state_q <= CH_RUN;
      tap_idx <= '0;
      half_q  <= half_mode;
      clk_en  <= 1'b1;
    end else if (state_q == CH_RUN) begin
      if (last_tap) begin
        state_q <= CH_DONE;
        tap_idx <= '0;
        clk_en  <= 1'b0;
      end else begin
        tap_idx <= tap_idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/fir_serial_channel.sv
module fir_serial_channel #(
  parameter int DATA_W    = 8,
  parameter int COEF_W    = 8,
  parameter int TAPS_FULL = 30,
  parameter int TAPS_HALF = 15,
  parameter int ACC_W     = 21,
  localparam int ADDR_W   = $clog2(TAPS_FULL)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              half_mode,
  input  logic              sample_stb,
  input  logic [DATA_W-1:0] sample_in,
  input  logic              coef_we,
  input  logic [ADDR_W-1:0] coef_addr,
  input  logic [COEF_W-1:0] coef_wdata,
  output logic [ACC_W-1:0]  result,
  output logic              result_valid,
  output logic              clk_en,
  output logic              overrun
);
  logic              shift_en, mac_clear, mac_step, finish;
  logic [ADDR_W-1:0] tap_idx;
  logic [DATA_W-1:0] tap_sample;
  logic [COEF_W-1:0] tap_coef;
  logic [ACC_W-1:0]  mac_sum;

  fir_chan_ctrl #(.TAPS_FULL(TAPS_FULL), .TAPS_HALF(TAPS_HALF), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst(rst), .enable(enable), .sample_stb(sample_stb), .half_mode(half_mode),
    .shift_en(shift_en), .mac_clear(mac_clear), .mac_step(mac_step), .finish(finish),
    .tap_idx(tap_idx), .clk_en(clk_en), .overrun(overrun)
  );

  fir_delay_line #(.DATA_W(DATA_W), .DEPTH(TAPS_FULL), .ADDR_W(ADDR_W)) u_hist (
    .clk(clk), .rst(rst), .shift_en(shift_en), .din(sample_in),
    .raddr(tap_idx), .dout(tap_sample)
  );

  fir_coef_store #(.COEF_W(COEF_W), .DEPTH(TAPS_FULL), .ADDR_W(ADDR_W)) u_coef (
    .clk(clk), .we(coef_we), .waddr(coef_addr), .wdata(coef_wdata),
    .raddr(tap_idx), .rdata(tap_coef)
  );

  fir_mac #(.DATA_W(DATA_W), .COEF_W(COEF_W), .ACC_W(ACC_W)) u_mac (
    .clk(clk), .rst(rst), .clear(mac_clear), .step(mac_step),
    .sample(tap_sample), .coef(tap_coef), .sum(mac_sum)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result       <= '0;
      result_valid <= 1'b0;
    end else begin
      result_valid <= finish;
      if (finish) result <= mac_sum;
    end
  end
endmodule

// File: rtl/fir_serial_channel_chk.sv
module fir_serial_channel_chk #(
  parameter int TAPS_FULL = 30,
  parameter int TAPS_HALF = 15,
  parameter int ACC_W     = 21,
  localparam int CNT_W    = $clog2(TAPS_FULL + 2) + 1
) (
  input logic             clk,
  input logic             rst,
  input logic             enable,
  input logic             half_mode,
  input logic             sample_stb,
  input logic [ACC_W-1:0] result,
  input logic             result_valid,
  input logic             clk_en,
  input logic             overrun
);
  logic [CNT_W-1:0] run_cnt;
  logic             half_seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_cnt   <= '0;
      half_seen <= 1'b0;
    end else if (enable && sample_stb) begin
      run_cnt   <= '0;
      half_seen <= half_mode;
    end else if (clk_en && run_cnt != {CNT_W{1'b1}}) begin
      run_cnt <= run_cnt + 1'b1;
    end
  end

  a_r6_valid_one_cycle: assert property (@(posedge clk) disable iff (rst)
    result_valid |=> !result_valid);
  a_r6_gate_at_valid: assert property (@(posedge clk) disable iff (rst)
    result_valid |-> !clk_en);
  a_r6_tap_count: assert property (@(posedge clk) disable iff (rst)
    result_valid |-> (run_cnt == (half_seen ? CNT_W'(TAPS_HALF) : CNT_W'(TAPS_FULL))));
  a_r6_strobe_opens: assert property (@(posedge clk) disable iff (rst)
    (enable && sample_stb) |=> clk_en);
  a_r7_overrun_sticky: assert property (@(posedge clk) disable iff (rst)
    overrun |=> overrun);
  a_r8_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (!clk_en && !result_valid));
  a_r9_result_hold: assert property (@(posedge clk) disable iff (rst)
    !result_valid |-> $stable(result));
endmodule

bind fir_serial_channel fir_serial_channel_chk #(
  .TAPS_FULL(TAPS_FULL), .TAPS_HALF(TAPS_HALF), .ACC_W(ACC_W)
) u_chk (
  .clk(clk), .rst(rst), .enable(enable), .half_mode(half_mode), .sample_stb(sample_stb),
  .result(result), .result_valid(result_valid), .clk_en(clk_en), .overrun(overrun)
);

// File: tb/tb_fir_serial_channel.sv
module tb_fir_serial_channel;
  logic        clk = 1'b0;
  logic        rst, enable, half_mode, sample_stb, coef_we;
  logic [7:0]  sample_in, coef_wdata;
  logic [4:0]  coef_addr;
  logic [20:0] result;
  logic        result_valid, clk_en, overrun;

  int ntests = 0, nfail = 0;
  int cf [30];
  int hist [30];
  bit done = 0;

  always #10 clk = ~clk;

  fir_serial_channel dut (
    .clk(clk), .rst(rst), .enable(enable), .half_mode(half_mode), .sample_stb(sample_stb),
    .sample_in(sample_in), .coef_we(coef_we), .coef_addr(coef_addr), .coef_wdata(coef_wdata),
    .result(result), .result_valid(result_valid), .clk_en(clk_en), .overrun(overrun)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    ntests++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_coef(input int k, input int v);
    @(negedge clk);
    coef_we = 1'b1; coef_addr = 5'(k); coef_wdata = 8'(v);
    @(negedge clk);
    coef_we = 1'b0;
    cf[k] = v;
  endtask

  function automatic int expected(input bit hm);
    int n = hm ? 15 : 30;
    int s = 0;
    for (int k = 0; k < n; k++) s += cf[k] * hist[k];
    return s;
  endfunction

  // strobe one sample; history model moves only when accepted
  task automatic strobe(input int x, input bit hm, input bit accepted);
    @(negedge clk);
    sample_stb = 1'b1; sample_in = 8'(x); half_mode = hm;
    @(negedge clk);
    sample_stb = 1'b0;
    if (accepted) begin
      for (int k = 29; k > 0; k--) hist[k] = hist[k-1];
      hist[0] = x;
    end
  endtask

  // called at the first negedge after the accepting edge
  task automatic finish_chk(input bit hm, input string req);
    int lat = 0;
    int n = hm ? 15 : 30;
    int exp = expected(hm);
    chk(clk_en == 1'b1, "R6 clk_en after strobe", int'(clk_en), 1);
    while (!result_valid && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    chk(lat == n, "R6 latency", lat, n);
    chk(int'($signed(result)) == exp, req, int'($signed(result)), exp);
    chk(clk_en == 1'b0, "R6 clk_en low at valid", int'(clk_en), 0);
    @(negedge clk);
    chk(result_valid == 1'b0, "R6 valid one cycle", int'(result_valid), 0);
    chk(int'($signed(result)) == exp, "R9 result held", int'($signed(result)), exp);
  endtask

  task automatic run_sample(input int x, input bit hm, input string req);
    strobe(x, hm, 1'b1);
    finish_chk(hm, req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nfail++; ntests++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", ntests, nfail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; enable = 1'b1; half_mode = 1'b0; sample_stb = 1'b0;
    sample_in = '0; coef_we = 1'b0; coef_addr = '0; coef_wdata = '0;
    for (int k = 0; k < 30; k++) hist[k] = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(result_valid == 0, "R1 valid", int'(result_valid), 0);
    chk(clk_en == 0, "R1 clk_en", int'(clk_en), 0);
    chk(overrun == 0, "R1 overrun", int'(overrun), 0);
    chk(result == 0, "R1 result", int'(result), 0);

    // R2: distinct coefficient per index
    for (int k = 0; k < 30; k++) write_coef(k, ((k * 53 + 17) % 256) - 128);

    // R3/R4: impulse walked through all positions picks out each coefficient
    run_sample(1, 1'b0, "R4 impulse head");
    for (int p = 1; p < 30; p++) run_sample(0, 1'b0, "R3 impulse walk");
    chk(overrun == 0, "R7 no overrun yet", int'(overrun), 0);

    // R4/R5: all sample values in both tap modes
    for (int v = -128; v < 128; v++) run_sample(v, 1'b0, "R4 full sweep");
    for (int v = -128; v < 128; v++) run_sample((v * 7) % 128, 1'b1, "R5 half sweep");
    for (int v = 0; v < 20; v++) run_sample(v * 11 - 100, v[0], "R5 mode alternation");

    // R4: extreme sums
    for (int k = 0; k < 30; k++) write_coef(k, -128);
    for (int i = 0; i < 30; i++) run_sample(-128, 1'b0, "R4 max positive");
    chk(int'($signed(result)) == 491520, "R4 max value", int'($signed(result)), 491520);
    for (int i = 0; i < 30; i++) run_sample(127, 1'b0, "R4 max negative");
    chk(int'($signed(result)) == -487680, "R4 min value", int'($signed(result)), -487680);
    for (int k = 0; k < 30; k++) write_coef(k, ((k * 29 + 5) % 256) - 128);

    // R8: strobes ignored while disabled, history unchanged
    @(negedge clk); enable = 1'b0;
    strobe(99, 1'b0, 1'b0);
    for (int i = 0; i < 40; i++) begin
      chk(clk_en == 0 && result_valid == 0, "R8 disabled quiet", int'(clk_en), 0);
      @(negedge clk);
    end
    enable = 1'b1;
    run_sample(-3, 1'b0, "R8 history untouched");

    // R8: abandon mid-computation
    strobe(45, 1'b0, 1'b1);
    @(negedge clk); enable = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 40; i++) begin
      chk(clk_en == 0 && result_valid == 0, "R8 abandon", int'(result_valid), 0);
      @(negedge clk);
    end
    enable = 1'b1;
    chk(overrun == 0, "R7 overrun still clear", int'(overrun), 0);
    run_sample(12, 1'b1, "R8 after abandon");

    // R7: second strobe mid-computation restarts and sets sticky flag
    strobe(70, 1'b0, 1'b1);
    repeat (4) @(negedge clk);
    strobe(-90, 1'b0, 1'b1);
    finish_chk(1'b0, "R7 restart result");
    chk(overrun == 1, "R7 overrun set", int'(overrun), 1);
    run_sample(5, 1'b0, "R7 normal after overrun");
    chk(overrun == 1, "R7 overrun sticky", int'(overrun), 1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end
endmodule